// File: doc/BRIEF.md
# Vector Compare Predicate Generator

This block turns a conditional-branch comparison into a per-element predicate mask. It does not redirect the program. After a start pulse it steps through element indices 0 up to VL-1 and compares one pair of source operands per cycle. Each source is either one fixed register or a run of consecutive registers, chosen by its own vectorised flag. For every element whose comparison holds, the matching bit of a predicate word is set. The finished word is meant to be written back into an integer register as a bit mask.

When neither source is vectorised there is no mask to build. The block then evaluates the single comparison once and reports that an ordinary branch decision applies, together with its outcome. The operand registers are read through two combinational read ports that the block addresses itself. The register file must hold its contents while the block is busy.

Top module: `vcmp_predgen`

## Requirements
- R1: After reset, `busy`, `done`, `scalar_branch`, `branch_taken` and `pred_out` are all 0.
- R2: If both vectorised flags are 0, the block reads `src_a` and `src_b` once. It raises `done` together with `scalar_branch` one cycle after the start edge. `branch_taken` carries the comparison result and `pred_out` is 0.
- R3: For element i, a vectorised source is read from register (base + i) modulo NREG, and a scalar source from its base register for every i.
- R4: Bit i of `pred_out` is 1 exactly when the comparison for element i holds, for i below the effective VL. All higher bits are 0.
- R5: `cmp_sel` codes: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 never hold.
- R6: One element is handled per clock. `done` is a one-cycle pulse that appears VL cycles after the start edge. `pred_out` keeps the finished word until the next accepted start.
- R7: A vector request with VL of 0 completes on the start edge itself, so `done` is visible right after that edge, with `pred_out` 0. A VL above XLEN is treated as XLEN.
- R8: A start that arrives while `busy` is high is ignored. It produces no extra `done` and does not alter the result in progress.
- R9: `busy` is high from the accepted start edge until the last element is processed, and it is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| cmp_sel | input | 3 | Comparison code |
| vl | input | $clog2(XLEN+1) | Element count |
| src_a | input | $clog2(NREG) | First source base register |
| src_b | input | $clog2(NREG) | Second source base register |
| vec_a | input | 1 | First source is vectorised |
| vec_b | input | 1 | Second source is vectorised |
| rd_idx_a | output | $clog2(NREG) | Read address, first operand |
| rd_val_a | input | XLEN | Read data, first operand |
| rd_idx_b | output | $clog2(NREG) | Read address, second operand |
| rd_val_b | input | XLEN | Read data, second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| scalar_branch | output | 1 | Completion was an ordinary branch decision |
| branch_taken | output | 1 | Outcome of that branch decision |
| pred_out | output | XLEN | Finished predicate mask |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a long vector run. Its effect only shows up later, as a corrupted mask or a stray completion pulse. The stimulus launches a twenty-element operation and injects a conflicting scalar request a few cycles in. It then keeps watching `done` for several idle cycles after the expected completion. Register index wrap-around is reached by placing a vectorised base near the top of the register file. The reserved comparison codes are swept alongside the six defined ones over the same operands.

// File: rtl/vcmp_predgen.sv
module vcmp_predgen #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int VLW  = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      cmp_sel,
  input  logic [VLW-1:0]  vl,
  input  logic [IDXW-1:0] src_a,
  input  logic [IDXW-1:0] src_b,
  input  logic            vec_a,
  input  logic            vec_b,
  output logic [IDXW-1:0] rd_idx_a,
  input  logic [XLEN-1:0] rd_val_a,
  output logic [IDXW-1:0] rd_idx_b,
  input  logic [XLEN-1:0] rd_val_b,
  output logic            busy,
  output logic            done,
  output logic            scalar_branch,
  output logic            branch_taken,
  output logic [XLEN-1:0] pred_out
);
  localparam int ELW = $clog2(XLEN);
  localparam int SW  = ((IDXW > VLW) ? IDXW : VLW) + 1;

  logic            busy_q, done_q, sbr_q, taken_q;
  logic [2:0]      sel_q;
  logic [IDXW-1:0] base_a_q, base_b_q;
  logic            vec_a_q, vec_b_q;
  logic [VLW-1:0]  cnt_q, elem_q;
  logic [XLEN-1:0] acc_q, pred_q;

  logic [VLW-1:0]  vl_eff;
  logic [SW-1:0]   sum_a, sum_b;
  logic            hit, last, scalar_q;
  logic [XLEN-1:0] acc_next;

  assign vl_eff   = (vl > VLW'(XLEN)) ? VLW'(XLEN) : vl;
  assign scalar_q = !vec_a_q && !vec_b_q;

  assign sum_a    = SW'(base_a_q) + (vec_a_q ? SW'(elem_q) : '0);
  assign sum_b    = SW'(base_b_q) + (vec_b_q ? SW'(elem_q) : '0);
  assign rd_idx_a = IDXW'(sum_a % SW'(NREG));
  assign rd_idx_b = IDXW'(sum_b % SW'(NREG));

  always_comb begin
    case (sel_q)
      3'b000:  hit = (rd_val_a == rd_val_b);
      3'b001:  hit = (rd_val_a != rd_val_b);
      3'b100:  hit = ($signed(rd_val_a) <  $signed(rd_val_b));
      3'b101:  hit = ($signed(rd_val_a) >= $signed(rd_val_b));
      3'b110:  hit = (rd_val_a <  rd_val_b);
      3'b111:  hit = (rd_val_a >= rd_val_b);
      default: hit = 1'b0;
    endcase
  end

  assign last     = (elem_q == cnt_q - VLW'(1));
  assign acc_next = acc_q | (hit ? (XLEN'(1) << elem_q[ELW-1:0]) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sbr_q    <= 1'b0;
      taken_q  <= 1'b0;
      sel_q    <= '0;
      base_a_q <= '0;
      base_b_q <= '0;
      vec_a_q  <= 1'b0;
      vec_b_q  <= 1'b0;
      cnt_q    <= '0;
      elem_q   <= '0;
      acc_q    <= '0;
      pred_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      sbr_q   <= 1'b0;
      taken_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          sel_q    <= cmp_sel;
          base_a_q <= src_a;
          base_b_q <= src_b;
          vec_a_q  <= vec_a;
          vec_b_q  <= vec_b;
          elem_q   <= '0;
          acc_q    <= '0;
          pred_q   <= '0;
          if (!vec_a && !vec_b) begin
            cnt_q  <= VLW'(1);
            busy_q <= 1'b1;
          end else if (vl_eff == '0) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q  <= vl_eff;
            busy_q <= 1'b1;
          end
        end
      end else begin
        acc_q  <= acc_next;
        elem_q <= elem_q + VLW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (scalar_q) begin
            sbr_q   <= 1'b1;
            taken_q <= hit;
          end else begin
            pred_q  <= acc_next;
          end
        end
      end
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign scalar_branch = sbr_q;
  assign branch_taken  = taken_q;
  assign pred_out      = pred_q;
endmodule

// File: rtl/vcmp_predgen_chk.sv
module vcmp_predgen_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int VLW  = $clog2(XLEN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            scalar_branch,
  input logic            branch_taken,
  input logic [XLEN-1:0] pred_out,
  input logic [IDXW-1:0] rd_idx_a,
  input logic            vec_a_q,
  input logic [VLW-1:0]  cnt_q
);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_scalar_no_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_branch |-> (done && pred_out == '0));

  assert_taken_only_scalar_R2: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> scalar_branch);

  assert_upper_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !scalar_branch) |-> ((pred_out >> cnt_q) == '0));

  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && vec_a_q) |-> (rd_idx_a == IDXW'($past(rd_idx_a) + 1'b1)));
endmodule

bind vcmp_predgen vcmp_predgen_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .scalar_branch(scalar_branch), .branch_taken(branch_taken),
  .pred_out(pred_out), .rd_idx_a(rd_idx_a), .vec_a_q(vec_a_q), .cnt_q(cnt_q)
);

// File: tb/test_vcmp_predgen.sv
module test_vcmp_predgen;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int IDXW = $clog2(NREG);
  localparam int VLW  = $clog2(XLEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmp_sel = '0;
  logic [VLW-1:0] vl = '0;
  logic [IDXW-1:0] src_a = '0, src_b = '0;
  logic vec_a = 1'b0, vec_b = 1'b0;
  logic [IDXW-1:0] rd_idx_a, rd_idx_b;
  logic [XLEN-1:0] rd_val_a, rd_val_b;
  logic busy, done, scalar_branch, branch_taken;
  logic [XLEN-1:0] pred_out;

  logic [XLEN-1:0] rf [NREG];
  assign rd_val_a = rf[rd_idx_a];
  assign rd_val_b = rf[rd_idx_b];

  always #2.5 clk = ~clk;

  vcmp_predgen #(.XLEN(XLEN), .NREG(NREG)) i_vcmp_predgen (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_sel(cmp_sel), .vl(vl),
    .src_a(src_a), .src_b(src_b), .vec_a(vec_a), .vec_b(vec_b),
    .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a),
    .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b),
    .busy(busy), .done(done), .scalar_branch(scalar_branch),
    .branch_taken(branch_taken), .pred_out(pred_out)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [XLEN-1:0] q_pred [$];
  logic            q_sbr  [$];
  logic            q_tk   [$];
  int              q_cyc  [$];
  string           q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cmp_f(input logic [2:0] s, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (s)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) <  $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a <  b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_pred.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " pred_out"}, pred_out, q_pred.pop_front());
        chk({t, " scalar_branch R2"}, XLEN'(scalar_branch), XLEN'(q_sbr.pop_front()));
        chk({t, " branch_taken R2"}, XLEN'(branch_taken), XLEN'(q_tk.pop_front()));
        chk({t, " done cycle R6"}, XLEN'(cyc), XLEN'(q_cyc.pop_front()));
      end
    end
  end

  task automatic launch(input string tag, input logic [2:0] s, input int n,
                        input int a, input int b, input logic va, input logic vb);
    int ne;
    int lat;
    logic [XLEN-1:0] ep;
    logic et;
    ne = (n > XLEN) ? XLEN : n;
    ep = '0;
    et = 1'b0;
    if (!va && !vb) begin
      lat = 1;
      et = cmp_f(s, rf[a], rf[b]);
    end else begin
      lat = ne;
      for (int i = 0; i < ne; i++)
        if (cmp_f(s, rf[(a + (va ? i : 0)) % NREG], rf[(b + (vb ? i : 0)) % NREG]))
          ep[i] = 1'b1;
    end
    @(negedge clk);
    q_pred.push_back(ep);
    q_sbr.push_back(!va && !vb);
    q_tk.push_back(et);
    q_cyc.push_back(cyc + 1 + lat);
    q_tag.push_back(tag);
    cmp_sel = s; vl = VLW'(n); src_a = IDXW'(a); src_b = IDXW'(b);
    vec_a = va; vec_b = vb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " busy R9"}, XLEN'(busy), XLEN'(lat > 0));
  endtask

  task automatic run_op(input string tag, input logic [2:0] s, input int n,
                        input int a, input int b, input logic va, input logic vb);
    logic [XLEN-1:0] ep;
    launch(tag, s, n, a, b, va, vb);
    ep = q_pred[0];
    while (q_pred.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " hold R6"}, pred_out, ep);
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NREG; i++)
      rf[i] = (i % 3 == 0) ? XLEN'(-(i * 5 + 1)) : XLEN'(i * 7);
    rf[5] = 32'h0000_0100;
    rf[6] = 32'h0000_0100;
    repeat (3) @(negedge clk);
    chk("R1 busy", XLEN'(busy), '0);
    chk("R1 done", XLEN'(done), '0);
    chk("R1 scalar_branch", XLEN'(scalar_branch), '0);
    chk("R1 branch_taken", XLEN'(branch_taken), '0);
    chk("R1 pred_out", pred_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R2 scalar eq taken", 3'b000, 5, 5, 6, 1'b0, 1'b0);
    run_op("R2 scalar lt not taken", 3'b100, 5, 7, 3, 1'b0, 1'b0);
    run_op("R2 scalar ltu taken", 3'b110, 0, 7, 3, 1'b0, 1'b0);

    for (int s = 0; s < 8; s++)
      run_op("R5 vector-vector code sweep", 3'(s), 8, 0, 3, 1'b1, 1'b1);

    run_op("R3 vector-scalar ltu", 3'b110, 16, 2, 9, 1'b1, 1'b0);
    run_op("R3 scalar-vector ge", 3'b101, 32, 12, 0, 1'b0, 1'b1);
    run_op("R3 wrap past top", 3'b100, 10, 27, 4, 1'b1, 1'b0);
    run_op("R4 full width ne", 3'b001, 32, 1, 1, 1'b1, 1'b0);
    run_op("R4 short vl eq", 3'b000, 3, 5, 6, 1'b1, 1'b0);

    run_op("R7 vl zero", 3'b001, 0, 1, 2, 1'b1, 1'b1);
    run_op("R7 vl clamp", 3'b111, 40, 0, 8, 1'b1, 1'b0);

    launch("R8 start while busy", 3'b110, 20, 1, 10, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    cmp_sel = 3'b000; vl = '0; src_a = 5; src_b = 6; vec_a = 0; vec_b = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q_pred.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);

    launch("R6 back to back a", 3'b100, 4, 0, 15, 1'b1, 1'b0);
    while (q_pred.size() != 0) @(negedge clk);
    launch("R6 back to back b", 3'b101, 4, 0, 15, 1'b1, 1'b0);
    while (q_pred.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    finish_up();
  end
endmodule